// File: doc/BRIEF.md
# Prescaled Backlight Pulse Generator

This block produces a pulse-width-modulated level for driving a display backlight controller. A reference clock is first divided by an 8-bit prescale factor. The divided ticks are then counted against a 16-bit scale value, which is the maximum brightness. A 16-bit brightness value sets how many of those ticks keep the output active. A byte-wide register port with write-enable, address, write data and registered read data holds the whole configuration.

The pulse does not have a dedicated pin. It shares one general-purpose pin with ordinary use. A function-select register gives every pin a 2-bit field that makes the pin an input, a plain output, or the special function. The pulse reaches the pin only when the pin wired to the generator selects the special function.

Changes to the prescaler, scale and brightness wait for the boundary of the current period. A running output therefore never shows a period made from a mix of old and new settings.

Top module: `bl_pwm_top`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. After reset every readable address returns 0, and every pin output enable is 0.
- R2: The register map is as follows. The prescaler is at 0xA0. The scale is at 0xA1 (low byte) and 0xA2 (high byte). The brightness is at 0xA3 (low byte) and 0xA4 (high byte). The control byte is at 0xA5. The function-select byte is at 0x5F. A read returns the stored byte one clock after the address is presented.
- R3: A read of any other address returns 0.
- R4: When enabled, one output period lasts prescale × scale + 1 reference cycles. A prescale value of 0 behaves as 1.
- R5: Each period is active for brightness × prescale cycles. A brightness of 0 gives a constant inactive level. A brightness at or above the scale, when not 0, gives a constant active level.
- R6: Control bit 0 inverts the output polarity. Active then means low and inactive means high.
- R7: While control bit 1 (enable) is 0, the output holds the inactive level and the counters stay at zero. After enable, a new period starts with its active phase one cycle after the control write lands.
- R8: A new prescaler, scale or brightness written during an enabled period takes effect only at the start of the next period.
- R9: Pin n uses bits [2n+1:2n] of the function-select byte. The value 0 means input (output enable 0). The value 1 means output, driven from pin_level[n]. The value 2 on pin 3 drives the pulse onto pin 3. The value 2 on any other pin, and the value 3 on any pin, leaves the output enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| pin_level | input | 4 | Level for each pin in plain-output mode |
| pin_out | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin output enables |

## Verification
The assertions check four things on every cycle. A disabled generator holds the inactive level and zeroed counters. The tick counter never passes the latched scale. The latched settings stay unchanged inside an enabled period. A pin whose field selects input never drives.

The bench scenarios cover what only spans whole periods. They measure period lengths and active-phase lengths for several prescale, scale and brightness sets, including prescale 0 and the constant levels. They check register readback. They also show that a brightness write made during an active phase leaves that phase at its old length and changes the next one.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int PRE_W = 8;
  localparam int CNT_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [7:0] A_PRE     = 8'hA0;
  localparam logic [7:0] A_SCALE_L = 8'hA1;
  localparam logic [7:0] A_SCALE_H = 8'hA2;
  localparam logic [7:0] A_BRT_L   = 8'hA3;
  localparam logic [7:0] A_BRT_H   = 8'hA4;
  localparam logic [7:0] A_CTRL    = 8'hA5;
  localparam logic [7:0] A_FSEL    = 8'h5F;

  typedef enum logic [1:0] {
    FN_IN  = 2'd0,
    FN_OUT = 2'd1,
    FN_ALT = 2'd2,
    FN_RSV = 2'd3
  } pin_fn_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] scale;
    logic [CNT_W-1:0] bright;
  } pwm_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [7:0]              addr,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [BYTE_W-1:0]       rdata,
  output pwm_cfg_t                cfg,
  output logic                    en,
  output logic                    inv,
  output logic [2*NUM_PINS-1:0]   fsel
);
  logic [1:0] ctrl_q;

  assign en  = ctrl_q[1];
  assign inv = ctrl_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      ctrl_q <= '0;
      fsel   <= '0;
    end else if (we) begin
      case (addr)
        A_PRE:     cfg.pre          <= wdata;
        A_SCALE_L: cfg.scale[7:0]   <= wdata;
        A_SCALE_H: cfg.scale[15:8]  <= wdata;
        A_BRT_L:   cfg.bright[7:0]  <= wdata;
        A_BRT_H:   cfg.bright[15:8] <= wdata;
        A_CTRL:    ctrl_q           <= wdata[1:0];
        A_FSEL:    fsel             <= wdata[2*NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_PRE:     rdata <= cfg.pre;
        A_SCALE_L: rdata <= cfg.scale[7:0];
        A_SCALE_H: rdata <= cfg.scale[15:8];
        A_BRT_L:   rdata <= cfg.bright[7:0];
        A_BRT_H:   rdata <= cfg.bright[15:8];
        A_CTRL:    rdata <= {6'd0, ctrl_q};
        A_FSEL:    rdata <= BYTE_W'(fsel);
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     inv,
  input  pwm_cfg_t cfg_live,
  output logic     pwm_q
);
  pwm_cfg_t         sh;
  logic [PRE_W-1:0] sub_q;
  logic [CNT_W-1:0] step_q;
  logic [PRE_W-1:0] pre_last;
  logic             period_end;
  logic             active;

  assign pre_last   = (sh.pre == '0) ? '0 : sh.pre - PRE_W'(1);
  assign period_end = (step_q == sh.scale);
  assign active     = (sh.bright != '0) &&
                      ((step_q < sh.bright) || (sh.bright >= sh.scale));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      sub_q  <= '0;
      step_q <= '0;
      pwm_q  <= 1'b0;
    end else if (!en) begin
      sh     <= cfg_live;
      sub_q  <= '0;
      step_q <= '0;
      pwm_q  <= inv;
    end else begin
      pwm_q <= active ^ inv;
      if (period_end) begin
        sh     <= cfg_live;
        sub_q  <= '0;
        step_q <= '0;
      end else if (sub_q == pre_last) begin
        sub_q  <= '0;
        step_q <= step_q + CNT_W'(1);
      end else begin
        sub_q <= sub_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/bl_pwm_pinmux.sv
module bl_pwm_pinmux
  import bl_pwm_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int PWM_PIN  = 3
) (
  input  logic [2*NUM_PINS-1:0] fsel,
  input  logic [NUM_PINS-1:0]   level,
  input  logic                  pwm,
  output logic [NUM_PINS-1:0]   pout,
  output logic [NUM_PINS-1:0]   poe
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_fn_e fn;
    assign fn = pin_fn_e'(fsel[2*p +: 2]);
    if (p == PWM_PIN) begin : g_alt
      assign poe[p]  = (fn == FN_OUT) || (fn == FN_ALT);
      assign pout[p] = (fn == FN_ALT) ? pwm : ((fn == FN_OUT) && level[p]);
    end else begin : g_plain
      assign poe[p]  = (fn == FN_OUT);
      assign pout[p] = (fn == FN_OUT) && level[p];
    end
  end
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int PWM_PIN  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [7:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic [NUM_PINS-1:0] pin_level,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  pwm_cfg_t              cfg_live;
  logic                  en;
  logic                  inv;
  logic [2*NUM_PINS-1:0] fsel;
  logic                  pwm_q;

  bl_pwm_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .cfg(cfg_live), .en(en), .inv(inv), .fsel(fsel)
  );

  bl_pwm_core u_core (
    .clk(clk), .rst(rst), .en(en), .inv(inv), .cfg_live(cfg_live), .pwm_q(pwm_q)
  );

  bl_pwm_pinmux #(.NUM_PINS(NUM_PINS), .PWM_PIN(PWM_PIN)) u_mux (
    .fsel(fsel), .level(pin_level), .pwm(pwm_q), .pout(pin_out), .poe(pin_oe)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic        inv,
  input logic        pwm,
  input logic [7:0]  sub,
  input logic [15:0] step,
  input logic [15:0] sh_scale,
  input logic [15:0] sh_bright,
  input logic [7:0]  sh_pre,
  input logic [1:0]  fn3,
  input logic        oe3
);
  a_r7_off_level: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pwm == $past(inv)));

  a_r7_counters_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (step == 16'd0 && sub == 8'd0));

  a_r4_step_bound: assert property (@(posedge clk) disable iff (rst)
    en |-> (step <= sh_scale));

  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && step != sh_scale) |=>
      ($stable(sh_scale) && $stable(sh_bright) && $stable(sh_pre)));

  a_r5_zero_dark: assert property (@(posedge clk) disable iff (rst)
    (en && sh_bright == 16'd0) |=> (pwm == $past(inv)));

  a_r9_input_quiet: assert property (@(posedge clk) disable iff (rst)
    (fn3 == 2'd0) |-> !oe3);
endmodule

bind bl_pwm_top bl_pwm_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .inv(inv), .pwm(pwm_q),
  .sub(u_core.sub_q), .step(u_core.step_q),
  .sh_scale(u_core.sh.scale), .sh_bright(u_core.sh.bright), .sh_pre(u_core.sh.pre),
  .fn3(fsel[7:6]), .oe3(pin_oe[3])
);

// File: tb/bl_pwm_top_test.sv
module bl_pwm_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [3:0] pin_level = 4'h0;
  logic [3:0] pin_out;
  logic [3:0] pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bl_pwm_top uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_level(pin_level),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic setup(input logic [7:0] pre, input logic [15:0] sc,
                       input logic [15:0] br, input logic [1:0] ctrl);
    wr(8'hA5, 8'h00);
    wr(8'hA0, pre);
    wr(8'hA1, sc[7:0]);  wr(8'hA2, sc[15:8]);
    wr(8'hA3, br[7:0]);  wr(8'hA4, br[15:8]);
    wr(8'hA5, {6'd0, ctrl});
  endtask

  task automatic count_high(input int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pin_out[3]) hi++;
    end
  endtask

  task automatic high_run(output int len);
    len = 0;
    while (!pin_out[3]) @(negedge clk);
    while (pin_out[3]) begin len++; @(negedge clk); end
  endtask

  task automatic rise_gap(output int gap);
    logic prev;
    gap = 0;
    prev = pin_out[3];
    while (!(pin_out[3] && !prev)) begin prev = pin_out[3]; @(negedge clk); end
    prev = 1'b1;
    @(negedge clk); gap = 1;
    while (!(pin_out[3] && !prev)) begin prev = pin_out[3]; @(negedge clk); gap++; end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check(pin_oe == 4'h0, "R1 oe after reset", pin_oe, 0);
    rd(8'hA1, d); check(d == 8'h00, "R1 scale low after reset", d, 0);
    rd(8'hA5, d); check(d == 8'h00, "R1 ctrl after reset", d, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    setup(8'h07, 16'h1234, 16'hBEEF, 2'b00);
    rd(8'hA0, d); check(d == 8'h07, "R2 prescale", d, 8'h07);
    rd(8'hA1, d); check(d == 8'h34, "R2 scale low", d, 8'h34);
    rd(8'hA2, d); check(d == 8'h12, "R2 scale high", d, 8'h12);
    rd(8'hA3, d); check(d == 8'hEF, "R2 bright low", d, 8'hEF);
    rd(8'hA4, d); check(d == 8'hBE, "R2 bright high", d, 8'hBE);
    rd(8'h10, d); check(d == 8'h00, "R3 unmapped 0x10", d, 0);
    rd(8'hA6, d); check(d == 8'h00, "R3 unmapped 0xA6", d, 0);
  endtask

  task automatic t_mux;
    logic [7:0] d;
    wr(8'h5F, 8'h00);
    @(negedge clk); check(pin_oe == 4'h0, "R9 all inputs", pin_oe, 0);
    wr(8'h5F, 8'h40); pin_level = 4'h8;
    @(negedge clk); check(pin_oe[3] && pin_out[3], "R9 plain output high", {pin_oe[3], pin_out[3]}, 3);
    pin_level = 4'h0;
    @(negedge clk); check(pin_oe[3] && !pin_out[3], "R9 plain output low", {pin_oe[3], pin_out[3]}, 2);
    wr(8'h5F, 8'h02);
    @(negedge clk); check(pin_oe == 4'h0, "R9 alt on pin0 stays off", pin_oe, 0);
    wr(8'h5F, 8'h80);
    rd(8'h5F, d); check(d == 8'h80, "R2 fsel readback", d, 8'h80);
    check(pin_oe == 4'h8, "R9 alt on pin3 drives", pin_oe, 8);
  endtask

  task automatic t_disable;
    setup(8'd3, 16'd10, 16'd4, 2'b00);
    repeat (3) @(negedge clk);
    check(pin_out[3] == 1'b0, "R7 disabled low", pin_out[3], 0);
    wr(8'hA5, 8'h01);
    repeat (2) @(negedge clk);
    check(pin_out[3] == 1'b1, "R7 disabled inverted high", pin_out[3], 1);
  endtask

  task automatic t_period;
    int v;
    setup(8'd3, 16'd10, 16'd4, 2'b10);
    @(negedge clk);
    check(pin_out[3] == 1'b1, "R7 active one cycle after enable", pin_out[3], 1);
    v = 1;
    while (pin_out[3]) begin @(negedge clk); if (pin_out[3]) v++; end
    check(v == 12, "R7 first run from zero", v, 12);
    rise_gap(v); check(v == 31, "R4 period 3x10+1", v, 31);
    count_high(93, v); check(v == 36, "R5 active 4x3 per period", v, 36);
    setup(8'd0, 16'd10, 16'd4, 2'b10);
    rise_gap(v); check(v == 11, "R4 prescale 0 acts as 1", v, 11);
    high_run(v); check(v == 4, "R5 run with prescale 0", v, 4);
  endtask

  task automatic t_levels;
    int v;
    setup(8'd2, 16'd10, 16'd0, 2'b10);
    count_high(60, v); check(v == 0, "R5 brightness 0 dark", v, 0);
    setup(8'd2, 16'd10, 16'd10, 2'b10);
    repeat (2) @(negedge clk);
    count_high(63, v); check(v == 63, "R5 brightness equals scale", v, 63);
    setup(8'd2, 16'd10, 16'd25, 2'b10);
    repeat (2) @(negedge clk);
    count_high(63, v); check(v == 63, "R5 brightness above scale", v, 63);
    setup(8'd3, 16'd10, 16'd4, 2'b11);
    repeat (2) @(negedge clk);
    count_high(93, v); check(v == 57, "R6 inverted high count", v, 57);
  endtask

  task automatic t_buffer;
    int v;
    setup(8'd2, 16'd20, 16'd5, 2'b10);
    @(negedge clk);
    v = pin_out[3] ? 1 : 0;
    reg_we = 1'b1; reg_addr = 8'hA3; reg_wdata = 8'd15;
    @(negedge clk);
    reg_we = 1'b0;
    if (pin_out[3]) v++;
    while (pin_out[3]) begin @(negedge clk); if (pin_out[3]) v++; end
    check(v == 10, "R8 current run keeps old brightness", v, 10);
    high_run(v); check(v == 30, "R8 next run uses new brightness", v, 30);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mux();
    t_disable();
    t_period();
    t_levels();
    t_buffer();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule